// File: doc/BRIEF.md
# Complementary Dead-Time Gate Sequencer

The sequencer turns a single PWM command into two switch commands that are never active together. One is a main power drive. The other is an auxiliary drive, the complement of the main one. Each handover between the two switches has its own dead time, counted in clock cycles and held in two registers:

- A rising command first releases the auxiliary switch. The power switch turns on once the rise dead time has run out.
- A falling command first releases the power switch. The auxiliary switch turns on once the fall dead time has run out.

A zero-voltage sense input belongs to each handover. While that handover's dead time is running, asserting the sense input ends the wait at once.

An enable input puts the block to sleep. In sleep the power drive is held low and the auxiliary drive is released: its output enable is deasserted. On waking, both switches stay off until the next PWM edge. A static parameter sets the auxiliary drive level. It can be the true complement of the power drive (high means on), or it can be inverted (low means on) to drive a p-channel switch.

The PWM, sense and enable inputs each pass through a two-flop synchroniser. Edge detection follows the synchroniser, and the output registers follow the edge detection. A change on an input therefore reaches the outputs three clock cycles later, plus any dead time. With a 250 MHz clock, dead times of 13 to 125 cycles span roughly 50 to 500 ns. This leaves ample margin for PWM frequencies up to 1 MHz.

Top module: `dt_gate_seq`

## Requirements
- R1: During and right after reset, pwr_o is 0, aux_oe_o is 0, and the auxiliary switch is off. Three cycles after reset is released with en_i held high, aux_oe_o becomes 1.
- R2: A rising pwm_i makes the auxiliary switch inactive 3 cycles later. pwr_o rises 3 + Ton cycles later, where Ton is the rise dead time.
- R3: A falling pwm_i makes pwr_o fall 3 cycles later. The auxiliary switch turns on 3 + Toff cycles later, where Toff is the fall dead time.
- R4: A dead time programmed as 0 behaves exactly like a dead time of 1 cycle.
- R5: The two dead times are loaded together when dt_wr_i is 1 at a clock edge, and each one governs only its own handover, for every pair of values.
- R6: Raising zvs_on_i while the rise dead time is running turns pwr_o on 3 cycles after the sense change. zvs_off_i does the same for the auxiliary turn-on. A sense input asserted outside its own wait has no effect.
- R7: A falling pwm_i during the rise dead time cancels the power turn-on and starts the fall dead time. A rising pwm_i during the fall dead time cancels the auxiliary turn-on and starts the rise dead time.
- R8: Three cycles after en_i falls, pwr_o is 0, aux_oe_o is 0 and aux_o sits at its off level. pwm_i toggling during sleep leaves these unchanged.
- R9: Three cycles after en_i rises, aux_oe_o is 1. Both switches stay off until the next pwm_i edge, and an edge after that is sequenced normally.
- R10: With AUX_INV = 0 the auxiliary switch is on when aux_o is 1. With AUX_INV = 1 it is on when aux_o is 0. The two settings give bit-inverse aux_o values for the same stimulus.
- R11: pwr_o and the auxiliary switch are never both on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low puts the block to sleep (asynchronous, synchronised inside) |
| pwm_i | input | 1 | PWM command (asynchronous) |
| zvs_on_i | input | 1 | Zero-voltage sense that ends the rise dead time |
| zvs_off_i | input | 1 | Zero-voltage sense that ends the fall dead time |
| dt_wr_i | input | 1 | Load strobe for both dead-time registers |
| dt_on_i | input | DT_W | Rise dead time in cycles (0 is treated as 1) |
| dt_off_i | input | DT_W | Fall dead time in cycles (0 is treated as 1) |
| pwr_o | output | 1 | Power switch drive, active high |
| aux_o | output | 1 | Auxiliary switch drive; level set by AUX_INV |
| aux_oe_o | output | 1 | Output enable for aux_o; 0 means high impedance |

## Verification
The bench builds two copies of the block with DT_W = 4, one with AUX_INV = 1 and one with AUX_INV = 0, and drives both from the same inputs. The 4-bit width makes every one of the 256 rise/fall dead-time pairs reachable, including the zero clamp, so both handover delays are swept exhaustively against the arithmetic expectation 3 + max(T, 1). The two polarity copies are compared in every sampled cycle. A full 15-cycle dead time leaves room to inject the sense inputs, the cancelling edges and the sleep/wake entries part-way through a wait.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_ON,
    ST_PWR,
    ST_WAIT_AUX,
    ST_AUX
  } dtg_state_e;
endpackage

// File: rtl/dtg_sync.sv
module dtg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dtg_timer.sv
module dtg_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         run_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= W'(1);
    else if (load_i)                     cnt_q <= val_i;
    else if (run_i && cnt_q > W'(1))     cnt_q <= cnt_q - W'(1);
  end

  // last cycle of the wait: the count has reached one
  assign expire_o = run_i && (cnt_q == W'(1));
endmodule

// File: rtl/dt_gate_seq.sv
module dt_gate_seq
  import dtg_pkg::*;
#(
  parameter int   DT_W       = 8,
  parameter bit   AUX_INV    = 1'b0,
  parameter int   DT_ON_RST  = 16,
  parameter int   DT_OFF_RST = 16,
  parameter int   SYNC_STG   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            pwm_i,
  input  logic            zvs_on_i,
  input  logic            zvs_off_i,
  input  logic            dt_wr_i,
  input  logic [DT_W-1:0] dt_on_i,
  input  logic [DT_W-1:0] dt_off_i,
  output logic            pwr_o,
  output logic            aux_o,
  output logic            aux_oe_o
);
  localparam int NSYNC = 4;
  localparam logic [DT_W-1:0] DT_MIN = DT_W'(1);

  logic [NSYNC-1:0] raw, syn;
  logic en_s, pwm_s, zon_s, zoff_s;

  assign raw = {en_i, zvs_off_i, zvs_on_i, pwm_i};

  dtg_sync #(.W(NSYNC), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {en_s, zoff_s, zon_s, pwm_s} = syn;

  // dead-time registers, zero clamped to one cycle
  logic [DT_W-1:0] dt_on_q, dt_off_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dt_on_q  <= DT_W'(DT_ON_RST);
      dt_off_q <= DT_W'(DT_OFF_RST);
    end else if (dt_wr_i) begin
      dt_on_q  <= (dt_on_i  == '0) ? DT_MIN : dt_on_i;
      dt_off_q <= (dt_off_i == '0) ? DT_MIN : dt_off_i;
    end
  end

  // edge detect tracks the command even in sleep, so waking makes no edge
  logic pwm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_s;
  end

  logic rise, fall;
  assign rise = pwm_s & ~pwm_q;
  assign fall = ~pwm_s & pwm_q;

  dtg_state_e st_q, st_d;
  logic tm_load, tm_run, tm_exp;
  logic [DT_W-1:0] tm_val;

  assign tm_run = (st_q == ST_WAIT_ON) || (st_q == ST_WAIT_AUX);

  dtg_timer #(.W(DT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tm_load),
    .val_i   (tm_val),
    .run_i   (tm_run),
    .expire_o(tm_exp)
  );

  always_comb begin
    st_d    = st_q;
    tm_load = 1'b0;
    tm_val  = dt_on_q;
    if (!en_s) begin
      st_d = ST_OFF;
    end else if (rise) begin
      st_d    = ST_WAIT_ON;
      tm_load = 1'b1;
      tm_val  = dt_on_q;
    end else if (fall) begin
      st_d    = ST_WAIT_AUX;
      tm_load = 1'b1;
      tm_val  = dt_off_q;
    end else begin
      case (st_q)
        ST_WAIT_ON:  if (zon_s  || tm_exp) st_d = ST_PWR;
        ST_WAIT_AUX: if (zoff_s || tm_exp) st_d = ST_AUX;
        default:     st_d = st_q;
      endcase
    end
  end

  logic pwr_q, aux_on_q, oe_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_OFF;
      pwr_q    <= 1'b0;
      aux_on_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      pwr_q    <= (st_d == ST_PWR);
      aux_on_q <= (st_d == ST_AUX);
      oe_q     <= en_s;
    end
  end

  assign pwr_o    = pwr_q;
  assign aux_o    = aux_on_q ^ AUX_INV;
  assign aux_oe_o = oe_q;
endmodule

// File: rtl/dt_gate_seq_chk.sv
module dt_gate_seq_chk #(
  parameter bit AUX_INV = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_o,
  input logic aux_o,
  input logic aux_oe_o
);
  logic aux_act;
  assign aux_act = aux_oe_o && (aux_o != AUX_INV);

  a_r11_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_o && aux_act));

  a_r2_pwr_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_o) |-> $past(!aux_act));

  a_r3_aux_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aux_act) |-> $past(!pwr_o));

  a_r8_sleep_pwr_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_oe_o |-> (!pwr_o && aux_o == AUX_INV));

  a_r9_wake_both_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aux_oe_o) |-> (!pwr_o && !aux_act));
endmodule

bind dt_gate_seq dt_gate_seq_chk #(.AUX_INV(AUX_INV)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pwr_o   (pwr_o),
  .aux_o   (aux_o),
  .aux_oe_o(aux_oe_o)
);

// File: tb/dt_gate_seq_bench.sv
module dt_gate_seq_bench;
  localparam int DT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, pwm = 1'b0, zon = 1'b0, zoff = 1'b0, wr = 1'b0;
  logic [DT_W-1:0] dton = '0, dtoff = '0;
  logic pwr, aux, oe, pwr_c, aux_c, oe_c;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dt_gate_seq #(.DT_W(DT_W), .AUX_INV(1'b1), .DT_ON_RST(5), .DT_OFF_RST(5)) u_dt_gate_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pwm_i(pwm), .zvs_on_i(zon), .zvs_off_i(zoff),
    .dt_wr_i(wr), .dt_on_i(dton), .dt_off_i(dtoff),
    .pwr_o(pwr), .aux_o(aux), .aux_oe_o(oe));

  dt_gate_seq #(.DT_W(DT_W), .AUX_INV(1'b0), .DT_ON_RST(5), .DT_OFF_RST(5)) u_dt_gate_seq_cmp (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pwm_i(pwm), .zvs_on_i(zon), .zvs_off_i(zoff),
    .dt_wr_i(wr), .dt_on_i(dton), .dt_off_i(dtoff),
    .pwr_o(pwr_c), .aux_o(aux_c), .aux_oe_o(oe_c));

  logic aux_act;
  assign aux_act = oe && !aux;  // AUX_INV = 1: low means on

  int k;
  int t_pwr_on, t_pwr_off, t_aux_on, t_aux_off;
  bit seen_pwr, seen_aux;
  logic pwr_prev, aux_prev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mark();
    k = 0; t_pwr_on = -1; t_pwr_off = -1; t_aux_on = -1; t_aux_off = -1;
    seen_pwr = 0; seen_aux = 0;
    pwr_prev = pwr; aux_prev = aux_act;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      k++;
      chk(!(pwr && aux_act), "R11 overlap", int'(pwr && aux_act), 0);
      chk(pwr == pwr_c && oe == oe_c && aux == !aux_c, "R10 polarity",
          int'({pwr, oe, aux}), int'({pwr_c, oe_c, !aux_c}));
      if (pwr && !pwr_prev && t_pwr_on < 0) t_pwr_on = k;
      if (!pwr && pwr_prev && t_pwr_off < 0) t_pwr_off = k;
      if (aux_act && !aux_prev && t_aux_on < 0) t_aux_on = k;
      if (!aux_act && aux_prev && t_aux_off < 0) t_aux_off = k;
      seen_pwr |= pwr; seen_aux |= aux_act;
      pwr_prev = pwr; aux_prev = aux_act;
    end
  endtask

  task automatic prog(input int a, input int b);
    dton = DT_W'(a); dtoff = DT_W'(b); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(pwr == 0 && oe == 0 && aux == 1 && aux_c == 0, "R1 in reset",
        int'({pwr, oe, aux, aux_c}), 4'b0010);
    rst_n = 1'b1;
    mark();
    tick(3);
    chk(oe == 1 && pwr == 0 && !aux_act, "R1 after reset", int'({oe, pwr, aux_act}), 3'b100);

    // R2 R3 R4 R5 exhaustive dead-time sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        bit was_aux;
        prog(a, b);
        was_aux = aux_act;
        mark(); pwm = 1'b1; tick(24);
        chk(t_pwr_on == 3 + eff(a), "R2 R4 R5 power on delay", t_pwr_on, 3 + eff(a));
        if (was_aux) chk(t_aux_off == 3, "R2 aux off delay", t_aux_off, 3);
        mark(); pwm = 1'b0; tick(24);
        chk(t_pwr_off == 3, "R3 power off delay", t_pwr_off, 3);
        chk(t_aux_on == 3 + eff(b), "R3 R4 R5 aux on delay", t_aux_on, 3 + eff(b));
      end
    end

    // R7 fall during rise dead time cancels power turn-on
    prog(15, 4);
    mark(); pwm = 1'b1; tick(5);
    chk(!seen_pwr, "R7 no early power", int'(seen_pwr), 0);
    mark(); pwm = 1'b0; tick(24);
    chk(!seen_pwr, "R7 power cancelled", int'(seen_pwr), 0);
    chk(t_aux_on == 7, "R7 aux from fall", t_aux_on, 7);

    // R7 rise during fall dead time cancels aux turn-on
    prog(3, 15);
    mark(); pwm = 1'b1; tick(24);
    chk(t_pwr_on == 6, "R7 power setup", t_pwr_on, 6);
    mark(); pwm = 1'b0; tick(5);
    chk(!seen_aux, "R7 no early aux", int'(seen_aux), 0);
    mark(); pwm = 1'b1; tick(24);
    chk(!seen_aux, "R7 aux cancelled", int'(seen_aux), 0);
    chk(t_pwr_on == 6, "R7 power from rise", t_pwr_on, 6);

    // R6 sense ignored outside its wait
    mark(); zoff = 1'b1; tick(10); zoff = 1'b0; tick(4);
    chk(!seen_aux && pwr, "R6 sense ignored", int'({seen_aux, pwr}), 1);

    // R6 sense ends the dead times early
    prog(15, 15);
    mark(); pwm = 1'b0; tick(4); zoff = 1'b1; tick(20); zoff = 1'b0;
    chk(t_aux_on == 7, "R6 zvs_off early aux", t_aux_on, 7);
    tick(4);
    mark(); pwm = 1'b1; tick(6); zon = 1'b1; tick(18); zon = 1'b0;
    chk(t_pwr_on == 9, "R6 zvs_on early power", t_pwr_on, 9);
    tick(4);

    // R8 sleep
    mark(); en = 1'b0; tick(3);
    chk(pwr == 0 && oe == 0 && aux == 1 && t_pwr_off == 3, "R8 sleep entry",
        int'({pwr, oe, aux}) * 100 + t_pwr_off, 1 * 100 + 3);
    mark();
    for (int i = 0; i < 3; i++) begin
      pwm = ~pwm; tick(6);
    end
    chk(!seen_pwr && oe == 0 && aux == 1, "R8 pwm ignored in sleep",
        int'({seen_pwr, oe, aux}), 3'b001);

    // R9 wake with changed command level, no edge afterwards
    mark(); en = 1'b1; tick(3);
    chk(oe == 1, "R9 oe on wake", int'(oe), 1);
    tick(12);
    chk(!seen_pwr && !seen_aux, "R9 both off after wake", int'({seen_pwr, seen_aux}), 0);
    mark(); pwm = 1'b1; tick(24);
    chk(t_pwr_on == 18, "R9 normal after wake", t_pwr_on, 18);
    mark(); pwm = 1'b0; tick(24);
    chk(t_aux_on == 18, "R9 aux after wake", t_aux_on, 18);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule